// File: doc/BRIEF.md
# Byte-Lane Endianness Register Checker

This block is a small hardware sequencer that acts as a bus master towards one 32-bit register. It finds out whether the register's byte lanes line up with byte addresses under the numbering convention chosen for the run. The bus it drives carries per-lane write strobes and can issue either word-sized or byte-sized transfers. A byte read returns its byte on the low eight data bits.

A single start pulse launches two phases. In the first phase the checker stores a distinctive word with one full-width write. It then reads the word back one byte at a time and checks each byte against the byte that should live at that address. In the second phase it writes the bitwise complement of that word into the register one byte address at a time. After every one of those partial writes it reads the whole word and checks the mix of complemented and original bytes. The lane-numbering convention is selectable at run time: either little-endian (lowest address holds the least significant byte) or big-endian (lowest address holds the most significant byte).

The run ends at the first disagreement or after the last check. A one-cycle done pulse marks the end, and a held pass or fail flag gives the outcome. On a failure the checker also holds a report of where the run stopped and what it saw.

Top module: `endchk_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no start, bus_req, done, pass and fail are all low.
- R2: The first transfer of a run is a word write (bus_we=1, bus_byte=0, bus_addr=0) with all four strobes set and bus_wdata equal to the pattern 0x12345678.
- R3: Four byte reads follow (bus_we=0, bus_byte=1, bus_strb=0) at byte offsets 0, 1, 2, 3 in that order. Only bus_rdata[7:0] takes part in the compare, and bits [31:8] of a byte read have no effect on the outcome.
- R4: The expected byte at offset a is pattern bits [8a+7:8a] when big_endian=0, and bits [31-8a:24-8a] when big_endian=1.
- R5: The second phase issues byte writes (bus_we=1, bus_byte=1) at offsets 0, 1, 2, 3 in order. Each has exactly one strobe: lane a in little-endian mode, lane 3-a in big-endian mode. The strobed lane of bus_wdata carries the matching byte of the complement 0xEDCBA987.
- R6: Each second-phase byte write at offset k is followed by a word read (bus_we=0, bus_byte=0, bus_addr=0, bus_strb=0). The expected word holds complemented bytes in every lane whose byte address is k or lower, and the original pattern bytes in all other lanes.
- R7: On the first mismatch the checker stops issuing transfers, pulses done, raises fail and holds the report: fail_phase (0 = first phase, 1 = second phase), fail_step (the byte offset of that step), fail_expected, and fail_observed. In the first phase both values are zero-extended bytes.
- R8: When every check agrees, done pulses for exactly one cycle two cycles after the last read is accepted, and pass rises. pass and fail then hold until the next start.
- R9: The endianness select is sampled only when a run starts. Changes to it, and start pulses that arrive while a run is in progress, have no effect on that run.
- R10: While bus_req is high and bus_ack is low, bus_req and every transfer field stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a run when idle |
| big_endian | input | 1 | Lane numbering: 0 little-endian, 1 big-endian |
| bus_req | output | 1 | Transfer request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_byte | output | 1 | 1 byte-sized transfer, 0 word-sized |
| bus_addr | output | 2 | Byte offset inside the register |
| bus_strb | output | 4 | Per-lane write strobes |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer accepted this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run finished with no mismatch |
| fail | output | 1 | Run stopped on a mismatch |
| fail_phase | output | 1 | Phase of the failing step |
| fail_step | output | 2 | Byte offset of the failing step |
| fail_expected | output | 32 | Value the checker expected |
| fail_observed | output | 32 | Value the checker read |

## Verification
The bench builds the block with its defaults: a 32-bit word with four lanes, and the pattern 0x12345678. All four pattern bytes differ, and so do their complements. As a result, any swapped, mirrored or dropped lane changes a compared value, and the two numbering modes give different expectations at every offset. The register on the far side is a behavioural model whose own lane convention and write faults can be set independently of the checker. This lets the bench drive both clean passes and first-mismatch stops in each phase, and check the reported phase, step and values against hand-computed numbers.

// File: rtl/endchk_pkg.sv
package endchk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_CHECK = 2'd2,
    ST_FIN   = 2'd3
  } endchk_state_e;

  typedef struct packed {
    logic phase;
    logic is_read;
  } endchk_op_t;

endpackage

// File: rtl/endchk_lane_map.sv
module endchk_lane_map #(
  parameter int                  DATA_W  = 32,
  parameter logic [DATA_W-1:0]   PATTERN = 32'h1234_5678,
  localparam int                 LANES   = DATA_W / 8,
  localparam int                 AW      = $clog2(LANES)
) (
  input  endchk_pkg::endchk_op_t op,
  input  logic [AW-1:0]          step,
  input  logic                   big_endian,
  output logic                   cmd_we,
  output logic                   cmd_byte,
  output logic [AW-1:0]          cmd_addr,
  output logic [LANES-1:0]       cmd_strb,
  output logic [DATA_W-1:0]      cmd_wdata,
  output logic [DATA_W-1:0]      exp_val
);

  localparam logic [DATA_W-1:0] PAT_INV = ~PATTERN;

  logic [AW-1:0]     lane_sel;
  logic [7:0]        sel_byte;
  logic [DATA_W-1:0] inv_mask;
  logic [DATA_W-1:0] word_exp;

  // physical lane addressed by the current byte offset
  assign lane_sel = big_endian ? (AW'(LANES - 1) - step) : step;
  assign sel_byte = PATTERN[lane_sel*8 +: 8];

  // lanes whose byte address is at or below the current step
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [AW-1:0] addr_of;
    assign addr_of = big_endian ? AW'(LANES - 1 - j) : AW'(j);
    assign inv_mask[j*8 +: 8] = (addr_of <= step) ? 8'hFF : 8'h00;
  end

  assign word_exp = (PATTERN & ~inv_mask) | (PAT_INV & inv_mask);

  always_comb begin
    cmd_we    = 1'b0;
    cmd_byte  = 1'b0;
    cmd_addr  = '0;
    cmd_strb  = '0;
    cmd_wdata = '0;
    exp_val   = '0;
    case ({op.phase, op.is_read})
      2'b00: begin
        cmd_we    = 1'b1;
        cmd_strb  = '1;
        cmd_wdata = PATTERN;
      end
      2'b01: begin
        cmd_byte  = 1'b1;
        cmd_addr  = step;
        exp_val   = {{(DATA_W-8){1'b0}}, sel_byte};
      end
      2'b10: begin
        cmd_we    = 1'b1;
        cmd_byte  = 1'b1;
        cmd_addr  = step;
        cmd_strb  = LANES'(1) << lane_sel;
        cmd_wdata = PAT_INV;
      end
      default: begin
        exp_val   = word_exp;
      end
    endcase
  end

endmodule

// File: rtl/endchk_capture.sv
module endchk_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              byte_sel,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] obs
);

  logic [DATA_W-1:0] obs_d;

  // byte reads keep only the low byte
  always_comb begin
    obs_d = byte_sel ? {{(DATA_W-8){1'b0}}, rdata[7:0]} : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obs <= '0;
    end else if (cap_en) begin
      obs <= obs_d;
    end
  end

endmodule

// File: rtl/endchk_report.sv
module endchk_report #(
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              chk_en,
  input  logic              last,
  input  logic              phase,
  input  logic [AW-1:0]     step,
  input  logic [DATA_W-1:0] exp_val,
  input  logic [DATA_W-1:0] obs_val,
  output logic              mismatch,
  output logic              pass,
  output logic              fail,
  output logic              fail_phase,
  output logic [AW-1:0]     fail_step,
  output logic [DATA_W-1:0] fail_expected,
  output logic [DATA_W-1:0] fail_observed
);

  logic rec_en;
  logic pass_en;

  assign mismatch = (exp_val != obs_val);
  assign rec_en   = chk_en && mismatch;
  assign pass_en  = chk_en && !mismatch && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass          <= 1'b0;
      fail          <= 1'b0;
      fail_phase    <= 1'b0;
      fail_step     <= '0;
      fail_expected <= '0;
      fail_observed <= '0;
    end else if (clear) begin
      pass          <= 1'b0;
      fail          <= 1'b0;
      fail_phase    <= 1'b0;
      fail_step     <= '0;
      fail_expected <= '0;
      fail_observed <= '0;
    end else begin
      if (pass_en) begin
        pass <= 1'b1;
      end
      if (rec_en) begin
        fail          <= 1'b1;
        fail_phase    <= phase;
        fail_step     <= step;
        fail_expected <= exp_val;
        fail_observed <= obs_val;
      end
    end
  end

endmodule

// File: rtl/endchk_seq.sv
module endchk_seq #(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] PATTERN = 32'h1234_5678,
  localparam int               LANES   = DATA_W / 8,
  localparam int               AW      = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              big_endian,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_byte,
  output logic [AW-1:0]     bus_addr,
  output logic [LANES-1:0]  bus_strb,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              fail_phase,
  output logic [AW-1:0]     fail_step,
  output logic [DATA_W-1:0] fail_expected,
  output logic [DATA_W-1:0] fail_observed
);

  import endchk_pkg::*;

  localparam logic [AW-1:0] STEP_MAX = AW'(LANES - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  endchk_state_e     state_q, state_d;
  logic              phase_q, phase_d;
  logic [AW-1:0]     step_q, step_d;
  logic              rd_q, rd_d;
  logic              be_q, be_d;
  logic              ctl_en;
  logic              clr;
  logic              cap_en;
  logic              chk_en;
  logic              last;
  logic              mismatch;
  endchk_op_t        op;
  logic [DATA_W-1:0] exp_val;
  logic [DATA_W-1:0] obs_val;

  assign op.phase   = phase_q;
  assign op.is_read = rd_q;
  assign last       = phase_q && (step_q == STEP_MAX);

  endchk_lane_map #(
    .DATA_W  (DATA_W),
    .PATTERN (PATTERN)
  ) u_map (
    .op         (op),
    .step       (step_q),
    .big_endian (be_q),
    .cmd_we     (bus_we),
    .cmd_byte   (bus_byte),
    .cmd_addr   (bus_addr),
    .cmd_strb   (bus_strb),
    .cmd_wdata  (bus_wdata),
    .exp_val    (exp_val)
  );

  endchk_capture #(
    .DATA_W (DATA_W)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cap_en   (cap_en),
    .byte_sel (bus_byte),
    .rdata    (bus_rdata),
    .obs      (obs_val)
  );

  endchk_report #(
    .DATA_W (DATA_W)
  ) u_rep (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .clear         (clr),
    .chk_en        (chk_en),
    .last          (last),
    .phase         (phase_q),
    .step          (step_q),
    .exp_val       (exp_val),
    .obs_val       (obs_val),
    .mismatch      (mismatch),
    .pass          (pass),
    .fail          (fail),
    .fail_phase    (fail_phase),
    .fail_step     (fail_step),
    .fail_expected (fail_expected),
    .fail_observed (fail_observed)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    step_d  = step_q;
    rd_d    = rd_q;
    be_d    = be_q;
    clr     = 1'b0;
    cap_en  = 1'b0;
    chk_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_XFER;
          phase_d = 1'b0;
          step_d  = '0;
          rd_d    = 1'b0;
          be_d    = big_endian;
          clr     = 1'b1;
        end
      end
      ST_XFER: begin
        if (bus_ack) begin
          if (rd_q) begin
            cap_en  = 1'b1;
            state_d = ST_CHECK;
          end else begin
            rd_d = 1'b1;
          end
        end
      end
      ST_CHECK: begin
        chk_en = 1'b1;
        if (mismatch || last) begin
          state_d = ST_FIN;
        end else begin
          state_d = ST_XFER;
          if (!phase_q && (step_q == STEP_MAX)) begin
            phase_d = 1'b1;
            step_d  = '0;
            rd_d    = 1'b0;
          end else begin
            step_d = step_q + AW'(1);
            rd_d   = !phase_q;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  assign ctl_en = (state_d != state_q) || (state_q == ST_XFER);

  // register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      step_q  <= '0;
      rd_q    <= 1'b0;
      be_q    <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      phase_q <= phase_d;
      step_q  <= step_d;
      rd_q    <= rd_d;
      be_q    <= be_d;
    end
  end

  assign bus_req = (state_q == ST_XFER);
  assign done    = (state_q == ST_FIN);

endmodule

// File: rtl/endchk_seq_chk.sv
module endchk_seq_chk #(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] PATTERN = 32'h1234_5678,
  localparam int               LANES   = DATA_W / 8,
  localparam int               AW      = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_byte,
  input logic [AW-1:0]     bus_addr,
  input logic [LANES-1:0]  bus_strb,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              done,
  input logic              pass,
  input logic              fail
);

  p_hold_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_byte)
      && $stable(bus_addr) && $stable(bus_strb) && $stable(bus_wdata));

  p_word_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && !bus_byte |-> (bus_strb == '1) && (bus_wdata == PATTERN));

  p_read_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |-> bus_strb == '0);

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_byte |-> $countones(bus_strb) == 1);

  p_quiet_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

  p_verdict_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> !fail);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_verdict_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass || fail));

endmodule

bind endchk_seq endchk_seq_chk #(
  .DATA_W  (DATA_W),
  .PATTERN (PATTERN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_byte  (bus_byte),
  .bus_addr  (bus_addr),
  .bus_strb  (bus_strb),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack),
  .done      (done),
  .pass      (pass),
  .fail      (fail)
);

// File: tb/endchk_seq_tb.sv
`timescale 1ns/1ps
module endchk_seq_tb_top;

  localparam logic [31:0] PAT = 32'h1234_5678;
  localparam logic [31:0] INV = 32'hEDCB_A987;

  logic        clk = 1'b0;
  logic        rst_n, start, big_endian, bus_ack;
  logic [31:0] bus_rdata;
  logic        bus_req, bus_we, bus_byte, done, pass, fail, fail_phase;
  logic [1:0]  bus_addr, fail_step;
  logic [3:0]  bus_strb;
  logic [31:0] bus_wdata, fail_expected, fail_observed;

  always #2 clk = ~clk;

  endchk_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .big_endian(big_endian),
    .bus_req(bus_req), .bus_we(bus_we), .bus_byte(bus_byte), .bus_addr(bus_addr),
    .bus_strb(bus_strb), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .done(done), .pass(pass), .fail(fail),
    .fail_phase(fail_phase), .fail_step(fail_step),
    .fail_expected(fail_expected), .fail_observed(fail_observed)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // far-side register model
  logic [31:0] sreg;
  bit slave_be;
  int stuck_lane;
  bit junk_hi;

  // reference model state
  bit m_busy = 0;
  bit m_be, m_pass, m_fail, m_phase;
  int m_idx, m_step;
  logic [31:0] m_exp, m_obs;
  int cyc = 0;
  int done_at = -1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected transfer number idx of a run
  task automatic ref_op(input int idx, input bit be,
                        output bit we, output bit byt, output int addr,
                        output logic [3:0] strb, output logic [31:0] wd,
                        output logic [31:0] exp, output bit ph, output int st,
                        output string tag);
    we = 0; byt = 0; addr = 0; strb = 4'h0; wd = 32'h0; exp = 32'h0; ph = 0; st = 0;
    tag = "R2";
    if (idx == 0) begin
      we = 1; strb = 4'hF; wd = PAT;
    end else if (idx <= 4) begin
      st = idx - 1; byt = 1; addr = st; tag = "R3";
      exp = be ? ((PAT >> (8 * (3 - st))) & 32'hFF) : ((PAT >> (8 * st)) & 32'hFF);
    end else begin
      ph = 1; st = (idx - 5) / 2;
      if (((idx - 5) % 2) == 0) begin
        we = 1; byt = 1; addr = st; wd = INV; tag = "R5";
        strb = be ? (4'h1 << (3 - st)) : (4'h1 << st);
      end else begin
        logic [31:0] m;
        m = 32'h0; tag = "R6";
        for (int a = 0; a <= st; a++) m |= 32'hFF << (8 * (be ? 3 - a : a));
        exp = (PAT & ~m) | (INV & m);
      end
    end
  endtask

  // every clock: check done, drive the far side, compare each accepted transfer
  always @(negedge clk) begin
    cyc++;
    bus_ack = 1'b0;
    if (rst_n) begin
      chk(done == (cyc == done_at), "R8", "done timing", {31'b0, done}, {31'b0, cyc == done_at});
      if (!m_busy) chk(!bus_req, "R7", "no transfer when idle", {31'b0, bus_req}, 32'h0);
    end
    if (m_busy && bus_req && (cyc % 3 != 0)) begin
      bit we, byt, ph; int addr, st; logic [3:0] strb; logic [31:0] wd, exp, obs, lm;
      string tag;
      ref_op(m_idx, m_be, we, byt, addr, strb, wd, exp, ph, st, tag);
      chk({bus_we, bus_byte, bus_addr} == {we, byt, 2'(addr)}, tag, "kind/size/offset",
          {28'h0, bus_we, bus_byte, bus_addr}, {28'h0, we, byt, 2'(addr)});
      chk(bus_strb == strb, tag, "strobes", {28'h0, bus_strb}, {28'h0, strb});
      bus_ack = 1'b1;
      bus_rdata = 32'h0;
      if (we) begin
        lm = 32'h0;
        for (int l = 0; l < 4; l++) if (strb[l]) lm |= 32'hFF << (8 * l);
        chk((bus_wdata & lm) == (wd & lm), tag, "write data", bus_wdata & lm, wd & lm);
        for (int l = 0; l < 4; l++)
          if (bus_strb[l] && !(bus_byte && l == stuck_lane))
            sreg[8*l +: 8] = bus_wdata[8*l +: 8];
        m_idx++;
      end else begin
        if (bus_byte)
          bus_rdata = {junk_hi ? 24'hA5_5AA5 : 24'h0,
                       sreg[8*(slave_be ? 3 - int'(bus_addr) : int'(bus_addr)) +: 8]};
        else
          bus_rdata = sreg;
        obs = byt ? {24'h0, bus_rdata[7:0]} : bus_rdata;
        if (obs != exp) begin
          m_fail = 1; m_phase = ph; m_step = st; m_exp = exp; m_obs = obs;
          m_busy = 0; done_at = cyc + 2;
        end else if (m_idx == 12) begin
          m_pass = 1; m_busy = 0; done_at = cyc + 2;
        end
        m_idx++;
      end
    end
  end

  task automatic run(input bit be, input bit s_be, input int stuck, input bit junk,
                     input bit disturb);
    @(negedge clk);
    sreg = 32'h0; slave_be = s_be; stuck_lane = stuck; junk_hi = junk;
    big_endian = be; m_be = be; m_idx = 0; m_pass = 0; m_fail = 0;
    done_at = -1; m_busy = 1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (3) @(negedge clk);
      big_endian = !be;    // R9: ignored mid-run
      start = 1'b1;        // R9: ignored mid-run
      @(negedge clk);
      start = 1'b0;
    end
    while (m_busy || cyc <= done_at) @(negedge clk);
    @(negedge clk);
    chk(pass == m_pass, "R8", "pass flag", {31'b0, pass}, {31'b0, m_pass});
    chk(fail == m_fail, "R7", "fail flag", {31'b0, fail}, {31'b0, m_fail});
    if (m_fail) begin
      chk(fail_phase == m_phase, "R7", "fail phase", {31'b0, fail_phase}, {31'b0, m_phase});
      chk(fail_step == 2'(m_step), "R7", "fail step", {30'b0, fail_step}, 32'(m_step));
      chk(fail_expected == m_exp, "R7", "fail expected", fail_expected, m_exp);
      chk(fail_observed == m_obs, "R7", "fail observed", fail_observed, m_obs);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; big_endian = 1'b0; bus_ack = 1'b0; bus_rdata = 32'h0;
    slave_be = 0; stuck_lane = -1; junk_hi = 0; sreg = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_req && !done && !pass && !fail, "R1", "reset state",
        {28'h0, bus_req, done, pass, fail}, 32'h0);

    // R4 R2 R3 R5 R6 R8: clean little-endian run
    run(1'b0, 1'b0, -1, 1'b0, 1'b0);
    chk(pass, "R8", "little-endian clean pass", {31'b0, pass}, 32'h1);
    // R4 R3 R9: big-endian, junk in upper read bits, mode and start disturbed
    run(1'b1, 1'b1, -1, 1'b1, 1'b1);
    chk(pass, "R9", "big-endian pass with disturbance", {31'b0, pass}, 32'h1);
    // R7 R4: little-endian checker against big-endian register
    run(1'b0, 1'b1, -1, 1'b0, 1'b0);
    chk(fail && fail_phase == 1'b0 && fail_step == 2'd0, "R7", "first-phase stop point",
        {29'h0, fail, fail_step}, {29'h0, 1'b1, 2'd0});
    chk(fail_expected == 32'h78 && fail_observed == 32'h12, "R4", "first-phase byte values",
        fail_observed, 32'h12);
    // R6 R7: lane 2 ignores byte writes, little-endian
    run(1'b0, 1'b0, 2, 1'b0, 1'b0);
    chk(fail_phase && fail_step == 2'd2 && fail_expected == 32'h12CB_A987,
        "R6", "little-endian stuck lane expected", fail_expected, 32'h12CB_A987);
    chk(fail_observed == 32'h1234_A987, "R6", "little-endian stuck lane observed",
        fail_observed, 32'h1234_A987);
    // R5 R6 R7: lane 2 ignores byte writes, big-endian
    run(1'b1, 1'b1, 2, 1'b0, 1'b0);
    chk(fail_phase && fail_step == 2'd1 && fail_expected == 32'hEDCB_5678,
        "R5", "big-endian stuck lane expected", fail_expected, 32'hEDCB_5678);
    chk(fail_observed == 32'hED34_5678, "R6", "big-endian stuck lane observed",
        fail_observed, 32'hED34_5678);
    // R8: a following clean run clears the old failure
    run(1'b1, 1'b1, -1, 1'b0, 1'b0);
    chk(pass && !fail, "R8", "verdict cleared by new start", {30'h0, pass, fail}, 32'h2);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

endmodule